// File: doc/BRIEF.md
# Multi-Mode Barrel Shifter

A combinational word shifter for datapaths that need logical shifts, arithmetic shifts and rotates from one piece of hardware. A data word of `WIDTH` bits (default 32) is moved by an amount of log2(`WIDTH`) bits, to the left or to the right. A two-bit mode field decides what enters the vacated positions: zeros, copies of the input's most significant bit, or the bits pushed out of the other end.

The network has log2(`WIDTH`) stages in a chain. Stage k moves its input by either 0 or 2^k positions, as amount bit k selects, so any amount from 0 to `WIDTH`-1 is a combination of stages. Every stage takes its sign fill from the most significant bit of the original word, so an arithmetic result does not depend on how the amount splits into stages. An enable input forces the whole result to zero after the last stage. `WIDTH` must be a power of two, so the amount is naturally taken modulo `WIDTH`.

Top module: `bshift_top`

## Requirements
- R1: When `en_i` is 0 the output `data_o` is all zeros, whatever the other inputs are.
- R2: Mode 2'b00 with `dir_left_i`=0 shifts `data_i` right by `amt_i` and fills the top `amt_i` bits with zeros.
- R3: Mode 2'b00 with `dir_left_i`=1 shifts `data_i` left by `amt_i` and fills the bottom `amt_i` bits with zeros.
- R4: Mode 2'b01 with `dir_left_i`=0 shifts right and fills the top `amt_i` bits with bit `WIDTH`-1 of `data_i` (a signed right shift), for every amount.
- R5: Mode 2'b01 with `dir_left_i`=1 gives the same result as a logical left shift.
- R6: Mode 2'b10 with `dir_left_i`=0 rotates right: bit i of the output is bit (i+`amt_i`) mod `WIDTH` of the input.
- R7: Mode 2'b10 with `dir_left_i`=1 rotates left: bit i of the output is bit (i-`amt_i`) mod `WIDTH` of the input.
- R8: With `en_i`=1 and `amt_i`=0 the output equals `data_i` in every mode and direction.
- R9: Mode 2'b11 behaves exactly as mode 2'b00 in both directions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| en_i | input | 1 | Output enable; 0 forces the result to zero |
| data_i | input | WIDTH | Word to be moved |
| amt_i | input | $clog2(WIDTH) | Shift or rotate distance |
| dir_left_i | input | 1 | 1 moves towards the MSB, 0 towards the LSB |
| mode_i | input | 2 | 00 logical, 01 arithmetic, 10 rotate, 11 logical |
| data_o | output | WIDTH | Moved word |

## Verification
The assertions watch properties that hold for any input on every evaluation: a disabled block gives zero, a zero amount passes the word through, a rotate keeps the number of set bits at every stage, a signed right shift keeps the sign bit, and a non-rotating left shift by a nonzero amount clears bit 0. Exact bit placement and fill content for each amount, including the sign fill over multi-stage amounts and the equivalence of the spare mode code with the logical mode, are shown only by the bench, which sweeps every amount in every mode and direction over several data patterns against expected values built from the language's own shift operators.

// File: rtl/bshift_pkg.sv
package bshift_pkg;

  typedef enum logic [1:0] {
    SHM_LOGIC  = 2'b00,
    SHM_ARITH  = 2'b01,
    SHM_ROTATE = 2'b10,
    SHM_SPARE  = 2'b11
  } shift_mode_e;

endpackage

// File: rtl/bshift_stage.sv
module bshift_stage
  import bshift_pkg::*;
#(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned STEP  = 1
) (
  input  logic [WIDTH-1:0] data_i,
  input  logic             sel_i,
  input  logic             dir_left_i,
  input  shift_mode_e      mode_i,
  input  logic             sign_i,
  output logic [WIDTH-1:0] data_o
);

  logic [STEP-1:0]  fill_hi;
  logic [STEP-1:0]  fill_lo;
  logic [WIDTH-1:0] moved;

  // fill_hi enters at the top on a right move, fill_lo at the bottom on a left move
  always_comb begin
    fill_hi = '0;
    fill_lo = '0;
    unique case (mode_i)
      SHM_ROTATE: begin
        fill_hi = data_i[STEP-1:0];
        fill_lo = data_i[WIDTH-1:WIDTH-STEP];
      end
      SHM_ARITH: fill_hi = {STEP{sign_i}};
      default: ;
    endcase
  end

  always_comb begin
    if (dir_left_i) moved = {data_i[WIDTH-1-STEP:0], fill_lo};
    else            moved = {fill_hi, data_i[WIDTH-1:STEP]};
    data_o = sel_i ? moved : data_i;
  end

  always_comb begin
    if (mode_i == SHM_ROTATE)
      AST_STAGE_ROT_BITS: assert ($countones(data_o) == $countones(data_i)) // R6
        else $error("rotate stage lost bits");
  end

endmodule

// File: rtl/bshift_gate.sv
module bshift_gate #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             en_i,
  input  logic [WIDTH-1:0] data_i,
  output logic [WIDTH-1:0] data_o
);

  assign data_o = data_i & {WIDTH{en_i}};

endmodule

// File: rtl/bshift_top.sv
module bshift_top
  import bshift_pkg::*;
#(
  parameter int unsigned WIDTH = 32,
  localparam int unsigned SHW  = $clog2(WIDTH)
) (
  input  logic             en_i,
  input  logic [WIDTH-1:0] data_i,
  input  logic [SHW-1:0]   amt_i,
  input  logic             dir_left_i,
  input  logic [1:0]       mode_i,
  output logic [WIDTH-1:0] data_o
);

  shift_mode_e      mode;
  logic             sign_bit;
  logic [WIDTH-1:0] chain [SHW+1];

  assign mode     = shift_mode_e'(mode_i);
  assign sign_bit = data_i[WIDTH-1];   // every stage fills from the original MSB
  assign chain[0] = data_i;

  for (genvar k = 0; k < SHW; k++) begin : g_stage
    bshift_stage #(
      .WIDTH (WIDTH),
      .STEP  (1 << k)
    ) u_stage (
      .data_i     (chain[k]),
      .sel_i      (amt_i[k]),
      .dir_left_i (dir_left_i),
      .mode_i     (mode),
      .sign_i     (sign_bit),
      .data_o     (chain[k+1])
    );
  end

  bshift_gate #(
    .WIDTH (WIDTH)
  ) u_gate (
    .en_i   (en_i),
    .data_i (chain[SHW]),
    .data_o (data_o)
  );

  always_comb begin
    if (!en_i)
      AST_DISABLED_ZERO: assert (data_o == '0) // R1
        else $error("output not zero while disabled");
    if (en_i && amt_i == '0)
      AST_ZERO_AMT_PASS: assert (data_o == data_i) // R8
        else $error("zero amount changed data");
    if (en_i && mode == SHM_ARITH && !dir_left_i)
      AST_ARITH_KEEPS_SIGN: assert (data_o[WIDTH-1] == data_i[WIDTH-1]) // R4
        else $error("signed right shift lost sign");
    if (en_i && mode == SHM_ROTATE)
      AST_ROT_POPCOUNT: assert ($countones(data_o) == $countones(data_i)) // R7
        else $error("rotate changed bit count");
    if (en_i && dir_left_i && mode != SHM_ROTATE && amt_i != '0)
      AST_LEFT_CLEARS_LSB: assert (data_o[0] == 1'b0) // R3
        else $error("left shift left lsb set");
  end

endmodule

// File: tb/sim_bshift_top.sv
module sim_bshift_top;

  localparam int unsigned W   = 32;
  localparam int unsigned SHW = $clog2(W);

  logic           clk = 1'b0;
  logic           en;
  logic [W-1:0]   din;
  logic [SHW-1:0] amt;
  logic           dir_left;
  logic [1:0]     mode;
  logic [W-1:0]   dout;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  bshift_top #(.WIDTH(W)) u0 (
    .en_i       (en),
    .data_i     (din),
    .amt_i      (amt),
    .dir_left_i (dir_left),
    .mode_i     (mode),
    .data_o     (dout)
  );

  localparam logic [W-1:0] PATS [6] = '{
    32'hC800_0000, 32'h8000_0001, 32'h1234_5678,
    32'hFFFF_FFFF, 32'h7FFF_FFFE, 32'hA5C3_0F96
  };

  task automatic apply_check(input logic e, input logic [W-1:0] d,
                             input int a, input logic l, input logic [1:0] m,
                             input logic [W-1:0] exp, input string req);
    @(negedge clk);
    en = e; din = d; amt = SHW'(a); dir_left = l; mode = m;
    #1;
    n_run++;
    if (dout !== exp) begin
      n_fail++;
      $display("FAIL %s d=%h amt=%0d left=%0b mode=%0d actual=%h expected=%h",
               req, d, a, l, m, dout, exp);
    end
  endtask

  function automatic logic [W-1:0] rot_r(logic [W-1:0] d, int a);
    logic [2*W-1:0] t = {d, d} >> a;
    return t[W-1:0];
  endfunction

  function automatic logic [W-1:0] rot_l(logic [W-1:0] d, int a);
    logic [2*W-1:0] t = {d, d} << a;
    return t[2*W-1:W];
  endfunction

  task automatic t_reset_state;
    apply_check(1'b0, '0, 0, 1'b0, 2'b00, '0, "R1");
  endtask

  task automatic t_disabled;  // R1
    foreach (PATS[p])
      for (int m = 0; m < 4; m++)
        apply_check(1'b0, PATS[p], 5 + m, m[0], 2'(m), '0, "R1");
  endtask

  task automatic t_logical;  // R2 R3
    foreach (PATS[p])
      for (int a = 0; a < W; a++) begin
        apply_check(1'b1, PATS[p], a, 1'b0, 2'b00, PATS[p] >> a, "R2");
        apply_check(1'b1, PATS[p], a, 1'b1, 2'b00, PATS[p] << a, "R3");
      end
  endtask

  task automatic t_arith;  // R4 R5
    foreach (PATS[p])
      for (int a = 0; a < W; a++) begin
        apply_check(1'b1, PATS[p], a, 1'b0, 2'b01,
                    W'($signed(PATS[p]) >>> a), "R4");
        apply_check(1'b1, PATS[p], a, 1'b1, 2'b01, PATS[p] << a, "R5");
      end
    // top bits 11001 moved right by 2 with sign fill
    apply_check(1'b1, 32'hC800_0000, 2, 1'b0, 2'b01, 32'hF200_0000, "R4");
  endtask

  task automatic t_rotate;  // R6 R7
    foreach (PATS[p])
      for (int a = 0; a < W; a++) begin
        apply_check(1'b1, PATS[p], a, 1'b0, 2'b10, rot_r(PATS[p], a), "R6");
        apply_check(1'b1, PATS[p], a, 1'b1, 2'b10, rot_l(PATS[p], a), "R7");
      end
    apply_check(1'b1, 32'h0000_0019, 2, 1'b0, 2'b10, 32'h4000_0006, "R6");
    apply_check(1'b1, 32'h8000_0000, 1, 1'b1, 2'b10, 32'h0000_0001, "R7");
  endtask

  task automatic t_zero_amount;  // R8
    foreach (PATS[p])
      for (int m = 0; m < 8; m++)
        apply_check(1'b1, PATS[p], 0, m[2], 2'(m), PATS[p], "R8");
  endtask

  task automatic t_spare_mode;  // R9
    foreach (PATS[p])
      for (int a = 0; a < W; a++) begin
        apply_check(1'b1, PATS[p], a, 1'b0, 2'b11, PATS[p] >> a, "R9");
        apply_check(1'b1, PATS[p], a, 1'b1, 2'b11, PATS[p] << a, "R9");
      end
  endtask

  initial begin
    en = 1'b0; din = '0; amt = '0; dir_left = 1'b0; mode = 2'b00;
    repeat (2) @(posedge clk);
    t_reset_state();
    t_disabled();
    t_logical();
    t_arith();
    t_rotate();
    t_zero_amount();
    t_spare_mode();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule